// File: doc/BRIEF.md
# Interrogation Burst Timing Generator

This block produces the timing skeleton of a single interrogation burst. A rising edge on the pulse-repetition trigger starts a burst, but only when the block is enabled and exactly one of the four interrogation modes is selected. The start opens a fixed window on an internally generated 1 µs clock and brings that clock out as a gated clock. A binary counter counts the falling edges of the gated clock. Its stage outputs are exposed as taps, and several fixed counts are decoded into strobes.

The decoded strobes are a sync enable and a zero reference. After the zero reference comes one pulse for the selected mode. That pulse sits at an offset that depends on the mode and is the only thing that differs between modes. All strobes come from registers, so the counter's carries cannot put glitches on them. Software-free: a mode selection and a trigger are all it takes to run a burst.

Top module: `intg_burst_timer`

## Requirements
- R1: A burst starts on the system clock edge that sees `prf_i` high after a cycle in which it was low. This happens only while `en_i` is high and exactly one bit of `mode_sel_i` is set (bit0 = mode 1, bit1 = mode 2, bit2 = mode 3/A, bit3 = mode C). `busy_o` is high from the first cycle after that edge.
- R2: While busy, `gclk_o` runs with a 1 µs period (2·HALF_CYC system cycles). Each period starts with a high half of HALF_CYC cycles. `busy_o` lasts exactly WINDOW_US periods. `gclk_o` is low whenever the block is idle.
- R3: `taps_o` is cleared when a burst starts and then counts the high-to-low transitions of `gclk_o`. It changes in the cycle after the gated clock falls, and never on a rising transition. Bit k of the taps is therefore high for 2^k µs at a time. After the window closes, the taps hold their final count (WINDOW_US).
- R4: `sync_en_o` is high for exactly one 1 µs period: the period in which the taps equal SYNC_AT (3). It rises one system cycle after the taps take that value.
- R5: `zref_o` is high for one 1 µs period, ZREF_GAP (4) periods after sync enable, while the taps equal SYNC_AT+ZREF_GAP (7). It is also delayed by one register stage.
- R6: Only the bit of `mode_pulse_o` for the latched mode pulses. The pulse is 1 µs wide, with the same one-cycle register delay, and sits while the taps equal 7 plus the mode offset. The offsets are 3 for mode 1, 5 for mode 2, 8 for mode 3/A and 21 for mode C.
- R7: A trigger edge that arrives during a burst is ignored, along with any change of `mode_sel_i`. Such a trigger neither lengthens the window nor changes the mode pulse.
- R8: With `rst_n` low, `busy_o`, `gclk_o`, `taps_o` and all strobes are zero. Reset takes effect at once, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable for accepting triggers |
| mode_sel_i | input | 4 | One-hot interrogation mode select |
| prf_i | input | 1 | Pulse-repetition trigger (level, edge detected) |
| gclk_o | output | 1 | Gated 1 µs clock |
| taps_o | output | CNT_W | Counter stage outputs |
| sync_en_o | output | 1 | Sync enable strobe |
| zref_o | output | 1 | Zero-reference strobe |
| mode_pulse_o | output | 4 | Per-mode interrogation pulse |
| busy_o | output | 1 | Burst window open |

## Verification
The bench builds the block with HALF_CYC = 2, so one microsecond is four system cycles and a whole 60 µs window takes 240 cycles. WINDOW_US, CNT_W, SYNC_AT and ZREF_GAP keep their default values. With this clock ratio every burst can be captured cycle by cycle, including mode C's late pulse. This makes the exact start, width and end of every strobe checkable. The short burst also leaves room for a mid-burst retrigger, a trigger held high and a mid-burst reset.

// File: rtl/intg_pkg.sv
package intg_pkg;
  localparam int unsigned NMODES = 4;

  // Offset in microseconds from the zero reference to the mode pulse
  function automatic int unsigned mode_offset(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 5;
      2:       return 8;
      default: return 21;
    endcase
  endfunction
endpackage

// File: rtl/intg_gate.sv
module intg_gate #(
  parameter int unsigned HALF_CYC  = 50,
  parameter int unsigned WINDOW_US = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic open_o,
  output logic gclk_o,
  output logic fall_o
);
  localparam int unsigned PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned NF_W = $clog2(WINDOW_US + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);
  localparam logic [NF_W-1:0] NF_END  = NF_W'(WINDOW_US);

  logic            open_q, open_n;
  logic            gclk_q, gclk_n;
  logic [PH_W-1:0] ph_q, ph_n;
  logic [NF_W-1:0] nf_q, nf_n;
  logic            ph_last, fall, close;

  assign ph_last = (ph_q == PH_LAST);
  assign fall    = open_q & gclk_q & ph_last;
  assign close   = open_q & ~gclk_q & ph_last & (nf_q == NF_END);

  always_comb begin
    open_n = open_q;
    gclk_n = gclk_q;
    ph_n   = ph_q;
    nf_n   = nf_q;
    if (start_i) begin
      open_n = 1'b1;
      gclk_n = 1'b1;
      ph_n   = '0;
      nf_n   = '0;
    end else if (open_q) begin
      ph_n = ph_last ? '0 : ph_q + 1'b1;
      if (ph_last) gclk_n = ~gclk_q;
      if (fall)    nf_n   = nf_q + 1'b1;
      if (close) begin
        open_n = 1'b0;
        gclk_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      gclk_q <= 1'b0;
      ph_q   <= '0;
      nf_q   <= '0;
    end else begin
      open_q <= open_n;
      gclk_q <= gclk_n;
      ph_q   <= ph_n;
      nf_q   <= nf_n;
    end
  end

  assign open_o = open_q;
  assign gclk_o = gclk_q;
  assign fall_o = fall;
endmodule

// File: rtl/intg_ripple.sv
module intg_ripple #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] q_o
);
  logic [CNT_W-1:0] q_q, q_n;
  logic [CNT_W:0]   carry;

  assign carry[0] = step_i;
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    assign carry[k+1] = carry[k] & q_q[k];
    always_comb q_n[k] = clr_i ? 1'b0 : (q_q[k] ^ carry[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_n;
  end

  assign q_o = q_q;
endmodule

// File: rtl/intg_decode.sv
module intg_decode #(
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned SYNC_AT  = 3,
  parameter int unsigned ZREF_GAP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       open_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [intg_pkg::NMODES-1:0] mode_i,
  output logic                       sync_o,
  output logic                       zref_o,
  output logic [intg_pkg::NMODES-1:0] pulse_o
);
  localparam int unsigned ZREF_AT = SYNC_AT + ZREF_GAP;
  localparam logic [CNT_W-1:0] SYNC_V = CNT_W'(SYNC_AT);
  localparam logic [CNT_W-1:0] ZREF_V = CNT_W'(ZREF_AT);

  logic                        sync_n, zref_n;
  logic [intg_pkg::NMODES-1:0] pulse_n;
  logic                        sync_q, zref_q;
  logic [intg_pkg::NMODES-1:0] pulse_q;

  assign sync_n = open_i & (cnt_i == SYNC_V);
  assign zref_n = open_i & (cnt_i == ZREF_V);

  for (genvar m = 0; m < intg_pkg::NMODES; m++) begin : g_mode
    localparam logic [CNT_W-1:0] SLOT_V =
      CNT_W'(ZREF_AT + intg_pkg::mode_offset(m));
    assign pulse_n[m] = open_i & mode_i[m] & (cnt_i == SLOT_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      zref_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      sync_q  <= sync_n;
      zref_q  <= zref_n;
      pulse_q <= pulse_n;
    end
  end

  assign sync_o  = sync_q;
  assign zref_o  = zref_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/intg_burst_timer.sv
module intg_burst_timer #(
  parameter int unsigned HALF_CYC  = 50,
  parameter int unsigned WINDOW_US = 60,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned SYNC_AT   = 3,
  parameter int unsigned ZREF_GAP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [3:0]       mode_sel_i,
  input  logic             prf_i,
  output logic             gclk_o,
  output logic [CNT_W-1:0] taps_o,
  output logic             sync_en_o,
  output logic             zref_o,
  output logic [3:0]       mode_pulse_o,
  output logic             busy_o
);
  logic       prf_q;
  logic [3:0] mode_q, mode_n;
  logic       open, fall, start;

  assign start = en_i & $onehot(mode_sel_i) & prf_i & ~prf_q & ~open;

  always_comb begin
    mode_n = mode_q;
    if (start) mode_n = mode_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prf_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      prf_q  <= prf_i;
      mode_q <= mode_n;
    end
  end

  intg_gate #(.HALF_CYC(HALF_CYC), .WINDOW_US(WINDOW_US)) gate_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .open_o(open), .gclk_o(gclk_o), .fall_o(fall)
  );

  intg_ripple #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .step_i(fall), .q_o(taps_o)
  );

  intg_decode #(.CNT_W(CNT_W), .SYNC_AT(SYNC_AT), .ZREF_GAP(ZREF_GAP)) dec_i (
    .clk(clk), .rst_n(rst_n), .open_i(open), .cnt_i(taps_o), .mode_i(mode_q),
    .sync_o(sync_en_o), .zref_o(zref_o), .pulse_o(mode_pulse_o)
  );

  assign busy_o = open;
endmodule

// File: rtl/intg_burst_timer_chk.sv
module intg_burst_timer_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             gclk_o,
  input logic [CNT_W-1:0] taps_o,
  input logic             sync_en_o,
  input logic             zref_o,
  input logic [3:0]       mode_pulse_o,
  input logic             busy_o
);
  // R1
  busy_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(en_i));

  // R2
  gclk_inside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gclk_o |-> busy_o);

  // R3
  taps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taps_o != $past(taps_o)) |-> ((taps_o == $past(taps_o) + 1'b1) || (taps_o == '0)));

  // R3
  taps_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(taps_o));

  // R4
  sync_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en_o |-> busy_o);

  // R5
  sync_zref_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_en_o && zref_o));

  // R6
  single_mode_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_pulse_o));
endmodule

bind intg_burst_timer intg_burst_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .gclk_o(gclk_o), .taps_o(taps_o),
  .sync_en_o(sync_en_o), .zref_o(zref_o), .mode_pulse_o(mode_pulse_o),
  .busy_o(busy_o)
);

// File: tb/intg_burst_timer_tb.sv
`timescale 1ns/1ps
module intg_burst_timer_tb_top;
  localparam int H   = 2;
  localparam int WIN = 60;
  localparam int CAP = 2 * H * WIN + 20;

  // {expect_accept, en, mode[3:0]}
  localparam logic [5:0] VEC [8] = '{
    6'b11_0001, 6'b11_0010, 6'b11_0100, 6'b11_1000,
    6'b00_0001, 6'b01_0000, 6'b01_0011, 6'b01_1100
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] mode = '0;
  logic prf = 1'b0;
  logic gclk, sync_en, zref, busy;
  logic [5:0] taps;
  logic [3:0] mpulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // capture results
  int s_first, s_w, z_first, z_w, p_first, p_w, p_other, busy_len, gclk_hi, gclk_idle;
  int tap_pre, tap_post, tap_rise;

  always #2.5 clk = ~clk;

  intg_burst_timer #(.HALF_CYC(H), .WINDOW_US(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_sel_i(mode), .prf_i(prf),
    .gclk_o(gclk), .taps_o(taps), .sync_en_o(sync_en), .zref_o(zref),
    .mode_pulse_o(mpulse), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int start_of(input int c);
    return 2 * H * (c - 1) + H + 1;
  endfunction

  function automatic int offs(input logic [3:0] m);
    case (m)
      4'b0001: return 3;
      4'b0010: return 5;
      4'b0100: return 8;
      default: return 21;
    endcase
  endfunction

  // Trigger at the coming edge, then capture CAP cycles (t=0 is the first cycle after it)
  task automatic burst(input logic e, input logic [3:0] m, input int rt_at,
                       input logic [3:0] rt_mode);
    s_first = -1; s_w = 0; z_first = -1; z_w = 0; p_first = -1; p_w = 0;
    p_other = 0; busy_len = 0; gclk_hi = 0; gclk_idle = 0;
    @(negedge clk);
    en = e; mode = m; prf = 1'b1;
    @(posedge clk);
    for (int t = 0; t < CAP; t++) begin
      @(negedge clk);
      if (t == 0) prf = 1'b0;
      if (t == rt_at) begin mode = rt_mode; prf = 1'b1; end
      if (t == rt_at + 2) prf = 1'b0;
      if (sync_en) begin if (s_first < 0) s_first = t; s_w++; end
      if (zref)    begin if (z_first < 0) z_first = t; z_w++; end
      if ((mpulse & m) != 0) begin if (p_first < 0) p_first = t; p_w++; end
      if ((mpulse & ~m) != 0) p_other++;
      if (busy) busy_len++;
      if (gclk) gclk_hi++;
      if (gclk && !busy) gclk_idle++;
      if (t == H - 1) tap_pre = int'(taps);
      if (t == H)     tap_post = int'(taps);
      if (t == 2 * H + 1) tap_rise = int'(taps);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!busy && !gclk && taps == 0 && !sync_en && !zref && mpulse == 0, "R8 reset",
        int'(taps), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [3:0] m;
      m = VEC[i][3:0];
      burst(VEC[i][4], m, -1, 4'b0000);
      if (VEC[i][5]) begin
        chk(busy_len == 2 * H * WIN, "R1/R2 window length", busy_len, 2 * H * WIN);
        chk(gclk_hi == H * WIN && gclk_idle == 0, "R2 gated clock duty", gclk_hi, H * WIN);
        chk(tap_pre == 0 && tap_post == 1 && tap_rise == 1, "R3 falling edge only",
            tap_rise, 1);
        chk(int'(taps) == WIN, "R3 final count", int'(taps), WIN);
        chk(s_first == start_of(3) && s_w == 2 * H, "R4 sync slot", s_first, start_of(3));
        chk(z_first == start_of(7) && z_w == 2 * H, "R5 zref slot", z_first, start_of(7));
        chk(p_first == start_of(7 + offs(m)) && p_w == 2 * H, "R6 mode pulse slot",
            p_first, start_of(7 + offs(m)));
        chk(p_other == 0, "R6 other mode bits quiet", p_other, 0);
      end else begin
        chk(busy_len == 0 && s_first < 0, "R1 trigger rejected", busy_len, 0);
      end
      repeat (3) @(negedge clk);
    end

    // R7: retrigger with another mode during a burst is ignored
    burst(1'b1, 4'b0001, 60, 4'b1000);
    chk(busy_len == 2 * H * WIN, "R7 window not extended", busy_len, 2 * H * WIN);
    chk(p_first == start_of(10) && p_other == 0, "R7 mode unchanged", p_first, start_of(10));
    repeat (3) @(negedge clk);

    // R1: trigger held high gives a single burst
    @(negedge clk); en = 1'b1; mode = 4'b0010; prf = 1'b1;
    busy_len = 0;
    for (int t = 0; t < CAP + 100; t++) begin
      @(negedge clk);
      if (busy) busy_len++;
    end
    chk(busy_len == 2 * H * WIN, "R1 level does not retrigger", busy_len, 2 * H * WIN);
    prf = 1'b0;
    repeat (3) @(negedge clk);

    // R8: reset in mid burst
    @(negedge clk); mode = 4'b0100; prf = 1'b1;
    repeat (30) @(negedge clk);
    prf = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!busy && !gclk && taps == 0, "R8 reset mid burst", int'(taps), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && taps == 0, "R8 stays idle after reset", int'(busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule